// File: doc/BRIEF.md
# Requester-ID to Stream-ID Translation Table

This block maps the 16-bit requester ID (bus, device and function) of an incoming PCIe transaction onto a 6-bit stream ID and a 3-bit auxiliary ID. An IOMMU and an interrupt translation service both consume the result. The table has a fixed count of entries. Each entry holds a valid flag, a stored requester ID, a 16-bit match mask and the two result fields.

Software never addresses an entry directly. It goes through three 32-bit registers on a simple single-cycle register bus: a control register that holds an entry index and an access flag, and two staging registers. A control write with the flag set loads the selected entry into the staging registers so that software can inspect it. A control write with the flag clear stores the staging registers into the selected entry.

A purely combinational lookup port compares a requester ID against every valid entry under that entry's mask. It reports a hit together with the stream ID and auxiliary ID of the lowest-numbered matching entry.

Top module: `rid_stream_map`

## Requirements
- R1: After reset every entry is invalid, and the control register and both staging registers read zero.
- R2: Word address 0 is the control register: the entry index is in bits 4:0 and the access flag is in bit 16. A read returns the last written index and flag, and all other bits read zero. Address 3 reads zero. Read data is combinational from the address.
- R3: Word address 1 is staging register A: valid in bit 31, auxiliary ID in bits 10:8, stream ID in bits 5:0. Other bits are not stored and read zero, so a stream ID of 64 or more keeps only its low 6 bits. Word address 2 is staging register B: requester ID in bits 31:16 and match mask in bits 15:0, all 32 bits readable.
- R4: Writes to the staging registers never change table contents or lookup results.
- R5: A control write with bit 16 set copies the indexed entry into both staging registers, readable from the next cycle, and leaves the table unchanged.
- R6: A control write with bit 16 clear stores both staging registers into the indexed entry on that clock edge. The lookup port reflects the new entry from the next cycle.
- R7: An entry hits only when it is valid and (lookup ID AND mask) equals (stored ID AND mask). A mask of 0xFFFF requires an exact match, and an invalid entry never hits.
- R8: When several entries hit, the lowest index supplies the stream and auxiliary IDs.
- R9: On a miss, the hit output is low and the stream and auxiliary ID outputs are zero.
- R10: Committing zero in both staging registers to an index removes that entry from lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address (0 control, 1 staging A, 2 staging B) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| lk_rid | input | 16 | Requester ID to translate |
| lk_hit | output | 1 | A valid entry matched |
| lk_sid | output | 6 | Stream ID of the winning entry |
| lk_aux | output | 3 | Auxiliary ID of the winning entry |

## Verification
Assertions check on every cycle that a miss drives zero results, that a hit comes from a valid entry and that no lower-indexed entry also matches. On each register access they check that a commit stores the staged valid flag, that a read-back copies the entry's flag without disturbing the table, and that staging writes leave the valid flags untouched. Only the bench scenarios show the full field packing, the masked matching against chosen IDs, the truncation of oversized stream IDs, and how priority shifts as overlapping entries are added and removed.

// File: rtl/rid_stream_map.sv
module rid_stream_map #(
  parameter int ENTRIES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [15:0] lk_rid,
  output logic        lk_hit,
  output logic [5:0]  lk_sid,
  output logic [2:0]  lk_aux
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int RID_W = 16;
  localparam int SID_W = 6;
  localparam int AUX_W = 3;
  localparam int ACC_BIT = 16;

  logic [IDX_W-1:0] ctl_idx;
  logic             ctl_acc;
  logic             sa_vld;
  logic [AUX_W-1:0] sa_aux;
  logic [SID_W-1:0] sa_sid;
  logic [31:0]      sb;

  logic [ENTRIES-1:0] ent_vld;
  logic [SID_W-1:0]   ent_sid [ENTRIES];
  logic [AUX_W-1:0]   ent_aux [ENTRIES];
  logic [RID_W-1:0]   ent_rid [ENTRIES];
  logic [RID_W-1:0]   ent_msk [ENTRIES];

  wire wr_ctl = bus_sel && bus_wr && (bus_addr == 2'd0);
  wire wr_sa  = bus_sel && bus_wr && (bus_addr == 2'd1);
  wire wr_sb  = bus_sel && bus_wr && (bus_addr == 2'd2);
  wire [IDX_W-1:0] w_idx = bus_wdata[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_idx <= '0;
      ctl_acc <= 1'b0;
      sa_vld  <= 1'b0;
      sa_aux  <= '0;
      sa_sid  <= '0;
      sb      <= '0;
      ent_vld <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_sid[i] <= '0;
        ent_aux[i] <= '0;
        ent_rid[i] <= '0;
        ent_msk[i] <= '0;
      end
    end else begin
      if (wr_sa) begin
        sa_vld <= bus_wdata[31];
        sa_aux <= bus_wdata[10:8];
        sa_sid <= bus_wdata[SID_W-1:0];
      end
      if (wr_sb) sb <= bus_wdata;
      if (wr_ctl) begin
        ctl_idx <= w_idx;
        ctl_acc <= bus_wdata[ACC_BIT];
        if (bus_wdata[ACC_BIT]) begin
          sa_vld <= ent_vld[w_idx];
          sa_aux <= ent_aux[w_idx];
          sa_sid <= ent_sid[w_idx];
          sb     <= {ent_rid[w_idx], ent_msk[w_idx]};
        end else begin
          ent_vld[w_idx] <= sa_vld;
          ent_aux[w_idx] <= sa_aux;
          ent_sid[w_idx] <= sa_sid;
          ent_rid[w_idx] <= sb[31:16];
          ent_msk[w_idx] <= sb[15:0];
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0: begin
        bus_rdata[ACC_BIT]     = ctl_acc;
        bus_rdata[IDX_W-1:0]   = ctl_idx;
      end
      2'd1: begin
        bus_rdata[31]          = sa_vld;
        bus_rdata[10:8]        = sa_aux;
        bus_rdata[SID_W-1:0]   = sa_sid;
      end
      2'd2: bus_rdata = sb;
      default: bus_rdata = '0;
    endcase
  end

  logic [ENTRIES-1:0] match;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = ent_vld[g] && (((lk_rid ^ ent_rid[g]) & ent_msk[g]) == '0);
  end

  logic             hit;
  logic [IDX_W-1:0] hidx;
  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit  = 1'b1;
        hidx = i[IDX_W-1:0];
      end
    end
  end

  assign lk_hit = hit;
  assign lk_sid = hit ? ent_sid[hidx] : '0;
  assign lk_aux = hit ? ent_aux[hidx] : '0;

  wire [ENTRIES-1:0] below = (ENTRIES'(1) << hidx) - ENTRIES'(1);

  a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_sid == '0 && lk_aux == '0));

  a_r7_hit_valid: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (ent_vld[hidx] && ((lk_rid & ent_msk[hidx]) == (ent_rid[hidx] & ent_msk[hidx]))));

  a_r8_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ((match & below) == '0));

  a_r6_commit_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !bus_wdata[ACC_BIT]) |=> (ent_vld[$past(w_idx)] == $past(sa_vld)));

  a_r5_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && bus_wdata[ACC_BIT]) |=> (sa_vld == $past(ent_vld[w_idx]) && $stable(ent_vld)));

  a_r4_staging_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sa || wr_sb) |=> $stable(ent_vld));
endmodule

// File: tb/tb_rid_stream_map.sv
module tb_rid_stream_map;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] lk_rid = '0;
  logic        lk_hit;
  logic [5:0]  lk_sid;
  logic [2:0]  lk_aux;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  rid_stream_map dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lk_rid(lk_rid), .lk_hit(lk_hit), .lk_sid(lk_sid), .lk_aux(lk_aux)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic look(input string tag, input logic [15:0] rid,
                      input logic hit, input logic [5:0] sid, input logic [2:0] aux);
    @(negedge clk);
    lk_rid = rid;
    #1 chk(tag, {22'b0, lk_hit, lk_sid, lk_aux}, {22'b0, hit, sid, aux});
  endtask

  task automatic put(input int idx, input logic [31:0] a, input logic [31:0] b);
    wr(2'd1, a);
    wr(2'd2, b);
    wr(2'd0, idx);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); chk("R1 ctl", d, 32'h0);
    rd(2'd1, d); chk("R1 stageA", d, 32'h0);
    rd(2'd2, d); chk("R1 stageB", d, 32'h0);
    look("R1 R9 miss after reset", 16'h0000, 1'b0, 6'd0, 3'd0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(2'd0, 32'h0001_0007);
    rd(2'd0, d); chk("R2 ctl readback", d, 32'h0001_0007);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R2 ctl reserved", d, 32'h0001_001F);
    rd(2'd3, d); chk("R2 addr3 zero", d, 32'h0);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R3 stageA fields", d, 32'h8000_073F);
    wr(2'd1, 32'h0000_0047);
    rd(2'd1, d); chk("R3 sid truncated", d, 32'h0000_0007);
    wr(2'd2, 32'hA5C3_0F0F);
    rd(2'd2, d); chk("R3 stageB", d, 32'hA5C3_0F0F);
    look("R4 no commit yet", 16'h0000, 1'b0, 6'd0, 3'd0);
  endtask

  task automatic t_commit();
    wr(2'd1, 32'h8000_0405);
    wr(2'd2, 32'h1234_FFFF);
    look("R4 staged only", 16'h1234, 1'b0, 6'd0, 3'd0);
    wr(2'd0, 32'd3);
    look("R6 committed", 16'h1234, 1'b1, 6'd5, 3'd4);
    look("R7 exact mask", 16'h1235, 1'b0, 6'd0, 3'd0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(2'd1, 32'h0000_0011);
    wr(2'd2, 32'h0000_0000);
    wr(2'd0, 32'h0001_0003);
    rd(2'd1, d); chk("R5 stageA loaded", d, 32'h8000_0405);
    rd(2'd2, d); chk("R5 stageB loaded", d, 32'h1234_FFFF);
    look("R5 table intact", 16'h1234, 1'b1, 6'd5, 3'd4);
  endtask

  task automatic t_mask();
    put(10, 32'h8000_0209, 32'h0100_FF00);
    look("R7 masked hit", 16'h01AB, 1'b1, 6'd9, 3'd2);
    look("R7 masked miss", 16'h02AB, 1'b0, 6'd0, 3'd0);
    put(5, 32'h0000_0101, 32'h4444_FFFF);
    look("R7 invalid no hit", 16'h4444, 1'b0, 6'd0, 3'd0);
  endtask

  task automatic t_priority();
    put(20, 32'h8000_0121, 32'h0100_FF00);
    look("R8 lower index wins", 16'h0155, 1'b1, 6'd9, 3'd2);
    put(2, 32'h8000_0701, 32'h0000_0000);
    look("R8 catch-all lowest", 16'h0155, 1'b1, 6'd1, 3'd7);
    look("R8 catch-all other", 16'h7777, 1'b1, 6'd1, 3'd7);
  endtask

  task automatic t_remove();
    logic [31:0] d;
    put(2, 32'h0, 32'h0);
    look("R10 removed idx2", 16'h0155, 1'b1, 6'd9, 3'd2);
    look("R9 miss zero", 16'h7777, 1'b0, 6'd0, 3'd0);
    put(10, 32'h0, 32'h0);
    look("R10 next entry wins", 16'h0155, 1'b1, 6'd33, 3'd1);
    wr(2'd0, 32'h0001_000A);
    rd(2'd1, d); chk("R10 readback cleared", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_commit();
    t_readback();
    t_mask();
    t_priority();
    t_remove();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule